// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command decoder that sits between a host bus and the program/erase sequencer of a byte-wide, block-erasable flash store. Each accepted bus write is a single-cycle strobe carrying an address and a data byte. The block decodes one-cycle instructions, which pick the read source, clear the status flags, or suspend or resume an erase. It also decodes two-cycle instructions, which program a byte or erase a block. It holds the status byte and reports the current read source as a 2-bit select, together with the byte to present when that source is internal (status or identifier).

Program and erase are not carried out here. When an instruction is complete and allowed, the block sends a one-cycle start pulse with the latched address and data to an external sequencer. It then waits for that sequencer's done pulse and its fail flag. Voltage conditions come in as already-decoded flags: program supply low, reset pin at unlock voltage, write-protect high, power-down and supply lockout. Before any start, the block checks whether the target lies in the protected top block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `rdSel` is 00 (array) and the status byte reads 80h.
- R2: Command FFh sets `rdSel` to 00 (array), 70h to 01 (status) and 90h to 10 (identifier). Any byte that is not a defined command leaves the read mode unchanged.
- R3: In identifier mode, `rdByte` is `MFR_CODE` when `rdA0` is 0 and `DEV_CODE` when `rdA0` is 1.
- R4: Set-up byte 40h or 10h followed by a second write raises `seqStartPgm` for exactly one cycle, in the cycle after that write. `seqAddr` and `seqData` hold that write's address and data. Status bit 7 reads 0 until `seqDone`, and `rdSel` reads 01 while the operation is busy.
- R5: Set-up byte 20h followed by D0h raises `seqStartErs` for one cycle. A second byte other than D0h sets status bits 5 and 4 and starts nothing.
- R6: While an erase runs, only 70h and B0h are honoured. B0h pulses `seqSuspend`, after which status reads C0h (bit 7 ready, bit 6 suspended).
- R7: While suspended, only FFh, 70h and D0h are honoured. D0h pulses `seqResume`, clears bit 6 and makes the block busy again.
- R8: A `seqDone` with `seqFail` high sets bit 4 after a program and bit 5 after an erase. Bits 5..3 stay set until command 50h. Bits 2..0 always read 0.
- R9: While any of status bits 5..3 is set, array mode is reported on `rdSel` as 01 (status).
- R10: A program or erase whose address has all bits above `BOOT_W` set (the protected top block) starts only when `unlockHv` or `wpHigh` is high. Otherwise it sets bit 4 (program) or bit 5 (erase) and starts nothing.
- R11: A program or erase second write made while `vppLow` is high sets bit 3 and starts nothing.
- R12: While `pwrDown` is high, `rdSel` is 11. On release the mode is array and bits 6..3 are cleared, so status reads 80h. A `lockout` pulse returns the mode to array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle accepted bus write |
| wrAddr | input | ADDR_W | Address of the bus write |
| wrData | input | 8 | Command or data byte of the bus write |
| rdA0 | input | 1 | Read address bit 0 (identifier select) |
| pwrDown | input | 1 | Reset pin at low level (power-down) |
| lockout | input | 1 | Supply lockout event |
| unlockHv | input | 1 | Reset pin at high unlock voltage |
| wpHigh | input | 1 | Write-protect pin high |
| vppLow | input | 1 | Program supply below operating level |
| seqDone | input | 1 | Sequencer finished the running operation |
| seqFail | input | 1 | Failure flag, valid with seqDone |
| seqStartPgm | output | 1 | Start-program pulse |
| seqStartErs | output | 1 | Start-erase pulse |
| seqSuspend | output | 1 | Erase-suspend pulse |
| seqResume | output | 1 | Erase-resume pulse |
| seqAddr | output | ADDR_W | Latched target address |
| seqData | output | 8 | Latched program data |
| rdSel | output | 2 | Read source: 00 array, 01 status, 10 identifier, 11 off |
| rdByte | output | 8 | Status or identifier byte (00h otherwise) |

## Verification
The mode-select commands are driven as a sequence that mixes them with undefined bytes such as 00h, 37h and ABh. This separates a decoder that holds its mode from one that falls back to a default. Program and erase are tried with a normal target, a protected target under each unlock flag, a low supply and a wrong confirm byte, so each refusal path is seen to set its own status bit. Commands written during a busy erase, a suspended erase and a busy program show whether filtering depends on the phase. Clearing, power-down and lockout are each applied over an existing error, to show which of them removes the sticky bits.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'b00,
    SEL_STATUS = 2'b01,
    SEL_IDENT  = 2'b10,
    SEL_OFF    = 2'b11
  } rdSel_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PGM  = 2'd1,
    PH_ERS  = 2'd2,
    PH_SUSP = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_PGM  = 2'd1,
    PEND_ERS  = 2'd2
  } pend_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PGM_A   = 8'h40;
  localparam logic [7:0] CMD_PGM_B   = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;

  typedef struct packed {
    logic latchOp;
    logic setVppErr;
    logic setPgmErr;
    logic setErsErr;
    logic clrSticky;
    logic clrAll;
  } ctlStb_t;
endpackage

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  logic       lockout,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       bootLocked,
  input  logic       vppLow,
  input  logic       seqDone,
  input  logic       seqFail,
  output rdSel_e     mode,
  output phase_e     phase,
  output ctlStb_t    stb,
  output logic       seqStartPgm,
  output logic       seqStartErs,
  output logic       seqSuspend,
  output logic       seqResume
);
  rdSel_e  nMode;
  phase_e  nPhase;
  pend_e   pend, nPend;
  logic    nStartPgm, nStartErs, nSuspend, nResume;

  always_comb begin
    nMode     = mode;
    nPhase    = phase;
    nPend     = pend;
    stb       = '0;
    nStartPgm = 1'b0;
    nStartErs = 1'b0;
    nSuspend  = 1'b0;
    nResume   = 1'b0;
    if (pwrDown) begin
      nMode      = SEL_ARRAY;
      nPhase     = PH_IDLE;
      nPend      = PEND_NONE;
      stb.clrAll = 1'b1;
    end else if (lockout) begin
      nMode = SEL_ARRAY;
      nPend = PEND_NONE;
    end else if (seqDone && (phase == PH_PGM || phase == PH_ERS)) begin
      nPhase = PH_IDLE;
      if (seqFail) begin
        stb.setPgmErr = (phase == PH_PGM);
        stb.setErsErr = (phase == PH_ERS);
      end
    end else if (wrStb) begin
      unique case (phase)
        PH_IDLE: begin
          if (pend == PEND_PGM) begin
            nPend = PEND_NONE;
            nMode = SEL_STATUS;
            if (vppLow)          stb.setVppErr = 1'b1;
            else if (bootLocked) stb.setPgmErr = 1'b1;
            else begin
              stb.latchOp = 1'b1;
              nStartPgm   = 1'b1;
              nPhase      = PH_PGM;
            end
          end else if (pend == PEND_ERS) begin
            nPend = PEND_NONE;
            nMode = SEL_STATUS;
            if (wrData != CMD_CONFIRM) begin
              stb.setPgmErr = 1'b1;
              stb.setErsErr = 1'b1;
            end else if (vppLow)     stb.setVppErr = 1'b1;
            else if (bootLocked)     stb.setErsErr = 1'b1;
            else begin
              stb.latchOp = 1'b1;
              nStartErs   = 1'b1;
              nPhase      = PH_ERS;
            end
          end else begin
            case (wrData)
              CMD_ARRAY:  nMode = SEL_ARRAY;
              CMD_STATUS: nMode = SEL_STATUS;
              CMD_IDENT:  nMode = SEL_IDENT;
              CMD_CLEAR:  stb.clrSticky = 1'b1;
              CMD_PGM_A, CMD_PGM_B: begin
                nPend = PEND_PGM;
                nMode = SEL_STATUS;
              end
              CMD_ERASE: begin
                nPend = PEND_ERS;
                nMode = SEL_STATUS;
              end
              default: ;
            endcase
          end
        end
        PH_PGM: begin
          if (wrData == CMD_STATUS) nMode = SEL_STATUS;
        end
        PH_ERS: begin
          if (wrData == CMD_STATUS) nMode = SEL_STATUS;
          else if (wrData == CMD_SUSPEND) begin
            nSuspend = 1'b1;
            nPhase   = PH_SUSP;
          end
        end
        PH_SUSP: begin
          case (wrData)
            CMD_ARRAY:  nMode = SEL_ARRAY;
            CMD_STATUS: nMode = SEL_STATUS;
            CMD_CONFIRM: begin
              nResume = 1'b1;
              nPhase  = PH_ERS;
              nMode   = SEL_STATUS;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= SEL_ARRAY;
      phase       <= PH_IDLE;
      pend        <= PEND_NONE;
      seqStartPgm <= 1'b0;
      seqStartErs <= 1'b0;
      seqSuspend  <= 1'b0;
      seqResume   <= 1'b0;
    end else begin
      mode        <= nMode;
      phase       <= nPhase;
      pend        <= nPend;
      seqStartPgm <= nStartPgm;
      seqStartErs <= nStartErs;
      seqSuspend  <= nSuspend;
      seqResume   <= nResume;
    end
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    seqStartPgm |=> !seqStartPgm);
  assert_erase_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    seqStartErs |-> (phase == PH_ERS));
  assert_suspend_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqSuspend |-> (phase == PH_SUSP && $past(phase) == PH_ERS));
  assert_resume_phase_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqResume |-> (phase == PH_ERS && $past(phase) == PH_SUSP));
endmodule

// File: rtl/fcc_data.sv
module fcc_data
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14,
  parameter logic [7:0] MFR_CODE = 8'h3C,
  parameter logic [7:0] DEV_CODE = 8'hA7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDown,
  input  ctlStb_t           stb,
  input  rdSel_e            mode,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdA0,
  input  logic              unlockHv,
  input  logic              wpHigh,
  output logic              bootLocked,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [7:0]        seqData,
  output rdSel_e            rdSel,
  output logic [7:0]        rdByte
);
  localparam int TOP_W = ADDR_W - BOOT_W;

  logic [2:0] sticky;   // status bits 5 (erase), 4 (program), 3 (supply)
  logic       busy;
  logic [7:0] statusByte;

  assign bootLocked = (wrAddr[ADDR_W-1:BOOT_W] == {TOP_W{1'b1}}) && !(unlockHv || wpHigh);
  assign busy       = (phase == PH_PGM) || (phase == PH_ERS);
  assign statusByte = {!busy, phase == PH_SUSP, sticky, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sticky  <= '0;
      seqAddr <= '0;
      seqData <= '0;
    end else begin
      if (stb.clrAll || stb.clrSticky) sticky <= '0;
      else sticky <= sticky | {stb.setErsErr, stb.setPgmErr, stb.setVppErr};
      if (stb.latchOp) begin
        seqAddr <= wrAddr;
        seqData <= wrData;
      end
    end
  end

  always_comb begin
    if (pwrDown)                            rdSel = SEL_OFF;
    else if (busy)                          rdSel = SEL_STATUS;
    else if (mode == SEL_ARRAY && |sticky)  rdSel = SEL_STATUS;
    else                                    rdSel = mode;
    unique case (rdSel)
      SEL_STATUS: rdByte = statusByte;
      SEL_IDENT:  rdByte = rdA0 ? DEV_CODE : MFR_CODE;
      default:    rdByte = 8'h00;
    endcase
  end

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clrSticky && !stb.clrAll) |=> ((sticky & $past(sticky)) == $past(sticky)));
  assert_pwrdown_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrDown) |-> (sticky == 3'b000));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14,
  parameter logic [7:0] MFR_CODE = 8'h3C,
  parameter logic [7:0] DEV_CODE = 8'hA7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdA0,
  input  logic              pwrDown,
  input  logic              lockout,
  input  logic              unlockHv,
  input  logic              wpHigh,
  input  logic              vppLow,
  input  logic              seqDone,
  input  logic              seqFail,
  output logic              seqStartPgm,
  output logic              seqStartErs,
  output logic              seqSuspend,
  output logic              seqResume,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [7:0]        seqData,
  output logic [1:0]        rdSel,
  output logic [7:0]        rdByte
);
  localparam int TOP_W = ADDR_W - BOOT_W;

  rdSel_e  mode, selE;
  phase_e  phase;
  ctlStb_t stb;
  logic    bootLocked;

  fcc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .lockout(lockout),
    .wrStb(wrStb), .wrData(wrData), .bootLocked(bootLocked), .vppLow(vppLow),
    .seqDone(seqDone), .seqFail(seqFail), .mode(mode), .phase(phase), .stb(stb),
    .seqStartPgm(seqStartPgm), .seqStartErs(seqStartErs),
    .seqSuspend(seqSuspend), .seqResume(seqResume)
  );

  fcc_data #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_data (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .stb(stb), .mode(mode), .phase(phase),
    .wrAddr(wrAddr), .wrData(wrData), .rdA0(rdA0), .unlockHv(unlockHv), .wpHigh(wpHigh),
    .bootLocked(bootLocked), .seqAddr(seqAddr), .seqData(seqData),
    .rdSel(selE), .rdByte(rdByte)
  );

  assign rdSel = selE;

  assert_boot_guard_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((seqStartPgm || seqStartErs) && seqAddr[ADDR_W-1:BOOT_W] == {TOP_W{1'b1}})
      |-> $past(unlockHv || wpHigh));
  assert_supply_guard_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seqStartPgm || seqStartErs) |-> !$past(vppLow));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [18:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rdA0 = 1'b0;
  logic        pwrDown = 1'b0, lockout = 1'b0, unlockHv = 1'b0, wpHigh = 1'b0, vppLow = 1'b0;
  logic        seqDone = 1'b0, seqFail = 1'b0;
  logic        seqStartPgm, seqStartErs, seqSuspend, seqResume;
  logic [18:0] seqAddr;
  logic [7:0]  seqData;
  logic [1:0]  rdSel;
  logic [7:0]  rdByte;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl u0 (.*);

  // {command byte, expected rdSel} for the mode walk (R2)
  localparam logic [9:0] MODE_VEC [10] = '{
    {8'h90, 2'b10}, {8'h37, 2'b10}, {8'h70, 2'b01}, {8'h00, 2'b01}, {8'hFF, 2'b00},
    {8'hAB, 2'b00}, {8'h90, 2'b10}, {8'hB0, 2'b10}, {8'hFF, 2'b00}, {8'hD0, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic done(input logic f);
    @(negedge clk);
    seqDone = 1'b1; seqFail = f;
    @(negedge clk);
    seqDone = 1'b0; seqFail = 1'b0;
  endtask

  task automatic readStatus(input string tag, input logic [7:0] exp);
    wr(19'h0, 8'h70);
    chk(tag, rdByte, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset rdSel", rdSel, 2'b00);
    readStatus("R1 reset status", 8'h80);
    wr(19'h0, 8'hFF);

    for (int i = 0; i < 10; i++) begin
      wr(19'h0, MODE_VEC[i][9:2]);
      chk($sformatf("R2 mode step %0d", i), rdSel, MODE_VEC[i][1:0]);
    end

    // R3 identifier
    wr(19'h0, 8'h90);
    rdA0 = 1'b0; #1 chk("R3 manufacturer code", rdByte, 8'h3C);
    rdA0 = 1'b1; #1 chk("R3 device code", rdByte, 8'hA7);
    rdA0 = 1'b0;

    // R4 program
    wr(19'h0, 8'h40);
    wr(19'h12345, 8'h5C);
    chk("R4 start pulse", seqStartPgm, 1'b1);
    chk("R4 latched addr", seqAddr, 19'h12345);
    chk("R4 latched data", seqData, 8'h5C);
    chk("R4 busy status", rdByte, 8'h00);
    @(negedge clk);
    chk("R4 pulse one cycle", seqStartPgm, 1'b0);
    wr(19'h0, 8'h90);
    chk("R4 busy reads status", rdSel, 2'b01);
    done(1'b0);
    chk("R4 ready after done", rdByte, 8'h80);

    // R8 / R9 program failure, sticky, gating of array mode
    wr(19'h0, 8'h10);
    wr(19'h00100, 8'h01);
    chk("R4 alt setup starts", seqStartPgm, 1'b1);
    done(1'b1);
    chk("R8 program error bit", rdByte, 8'h90);
    wr(19'h0, 8'hFF);
    chk("R9 array gated by error", rdSel, 2'b01);
    wr(19'h0, 8'h90);
    wr(19'h0, 8'hFF);
    chk("R8 error stays sticky", rdByte, 8'h90);
    wr(19'h0, 8'h50);
    chk("R8 clear restores array", rdSel, 2'b00);
    readStatus("R8 cleared status", 8'h80);

    // R5 / R6 / R7 erase with suspend and resume
    wr(19'h0, 8'h20);
    wr(19'h20000, 8'hD0);
    chk("R5 erase start", seqStartErs, 1'b1);
    chk("R5 erase busy status", rdByte, 8'h00);
    wr(19'h0, 8'hFF);
    chk("R6 FF ignored while erasing", rdSel, 2'b01);
    wr(19'h0, 8'hB0);
    chk("R6 suspend pulse", seqSuspend, 1'b1);
    chk("R6 suspended status", rdByte, 8'hC0);
    wr(19'h0, 8'hFF);
    chk("R7 array read in suspend", rdSel, 2'b00);
    wr(19'h00010, 8'h40);
    chk("R7 set-up ignored in suspend", rdSel, 2'b00);
    wr(19'h00010, 8'h33);
    chk("R7 no program start in suspend", seqStartPgm, 1'b0);
    readStatus("R7 still suspended", 8'hC0);
    wr(19'h0, 8'hD0);
    chk("R7 resume pulse", seqResume, 1'b1);
    chk("R7 resumed busy", rdByte, 8'h00);
    done(1'b1);
    chk("R8 erase error bit", rdByte, 8'hA0);
    wr(19'h0, 8'h50);

    // R5 bad confirm
    wr(19'h0, 8'h20);
    wr(19'h20000, 8'h55);
    chk("R5 no start on bad confirm", seqStartErs, 1'b0);
    chk("R5 bad confirm bits", rdByte, 8'hB0);
    wr(19'h0, 8'h50);

    // R10 boot protection
    wr(19'h0, 8'h40);
    wr(19'h7C000, 8'hAA);
    chk("R10 locked program refused", seqStartPgm, 1'b0);
    chk("R10 locked program error", rdByte, 8'h90);
    wr(19'h0, 8'h50);
    wpHigh = 1'b1;
    wr(19'h0, 8'h40);
    wr(19'h7C000, 8'hAA);
    chk("R10 wp unlock starts", seqStartPgm, 1'b1);
    done(1'b0);
    wpHigh = 1'b0; unlockHv = 1'b1;
    wr(19'h0, 8'h20);
    wr(19'h7FFFF, 8'hD0);
    chk("R10 hv unlock erase starts", seqStartErs, 1'b1);
    done(1'b0);
    unlockHv = 1'b0;
    wr(19'h0, 8'h20);
    wr(19'h7FFFF, 8'hD0);
    chk("R10 locked erase error", rdByte, 8'hA0);
    wr(19'h0, 8'h50);

    // R11 supply low
    vppLow = 1'b1;
    wr(19'h0, 8'h40);
    wr(19'h00200, 8'h11);
    chk("R11 no start when supply low", seqStartPgm, 1'b0);
    chk("R11 supply bit", rdByte, 8'h88);
    vppLow = 1'b0;
    wr(19'h0, 8'h50);
    readStatus("R11 cleared", 8'h80);

    // R12 power-down and lockout
    wr(19'h0, 8'h20);
    wr(19'h0, 8'h77);
    @(negedge clk);
    pwrDown = 1'b1;
    @(negedge clk);
    chk("R12 off while power-down", rdSel, 2'b11);
    pwrDown = 1'b0;
    @(negedge clk);
    chk("R12 array after power-down", rdSel, 2'b00);
    readStatus("R12 status cleared", 8'h80);
    wr(19'h0, 8'h90);
    lockout = 1'b1;
    @(negedge clk);
    lockout = 1'b0;
    @(negedge clk);
    chk("R12 lockout returns to array", rdSel, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule